// File: doc/BRIEF.md
# Vectored Interrupt Mask Unit

This block sits in front of a small 8-bit processor core and decides which of five interrupt request lines is serviced next. One line is non-maskable and outranks everything. Three lines have their own mask bits and fixed restart vectors. The fifth line is a general request that needs a vector supplied from outside. The three vectored lines and the general line are also gated by a global enable.

Every cycle the unit presents the winning request as a combinational result. That result is either a fixed vector address or a flag telling the core to fetch a vector from outside. The core pulses an acknowledge when it takes the interrupt.

A mask-write port loads the three individual masks and can discard a latched edge on the highest maskable line. A status port returns the masks, the global enable and the three pending flags. Separate enable and disable strobes control the global enable. An acknowledge always drops the global enable, so nested service has to be re-armed explicitly.

Top module: `irqv_front`

## Requirements
- R1: After synchronous reset all three masks are 1 (masked), the global enable is 0 and the edge latch is clear. `stat_o` reads 0x07 and `req_o` is 0.
- R2: A write with `mwr_i`=1 and `mwdata_i[3]`=1 loads `mwdata_i[2:0]` into the masks: bit 0 for the low line, bit 1 for the middle line, bit 2 for the edge line. When `mwdata_i[3]`=0 the masks keep their value.
- R3: `stat_o` packs the status as follows: [2:0] masks in the R2 order, [3] global enable, [4] low-line pending, [5] middle-line pending, [6] edge-line pending, [7] always 0.
- R4: When `nmi_i` is high, `req_o`=1 and `vec_o`=0x24, whatever the masks and the global enable are.
- R5: Among enabled requests the priority is edge line (0x3C), then middle line (0x34), then low line (0x2C), then the general line. A line competes only if the global enable is 1 and its own mask bit is 0.
- R6: When the general line wins, `req_o`=1, `ext_o`=1 and `vec_o`=0x00. In every other case `ext_o`=0, and with no winner `req_o`=0 and `vec_o`=0x00.
- R7: A 0-to-1 transition on `irq_edge_i` sets the edge-line pending latch on the next clock edge. The latch then holds after the pin falls. A pin held high does not set it again.
- R8: A write with `mwr_i`=1 and `mwdata_i[4]`=1 clears the edge latch. If a new rising edge arrives in the same cycle, the latch ends up set.
- R9: `ack_i` clears the global enable. It also clears the edge latch, but only when the edge line is the current winner.
- R10: `ei_i` sets the global enable and `di_i` clears it. When `di_i` or `ack_i` is asserted in the same cycle as `ei_i`, the enable ends up cleared.
- R11: The low-line and middle-line pending bits in `stat_o` follow their pins directly, even when the line is masked or the global enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, level |
| irq_edge_i | input | 1 | Highest maskable request, edge-latched |
| irq_mid_i | input | 1 | Middle maskable request, level |
| irq_low_i | input | 1 | Lowest maskable request, level |
| irq_ext_i | input | 1 | General request needing an external vector |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| ack_i | input | 1 | Core accepts the presented request |
| mwr_i | input | 1 | Mask-write strobe |
| mwdata_i | input | 5 | Mask-write data: [2:0] masks, [3] load masks, [4] clear edge latch |
| req_o | output | 1 | A request is being presented |
| ext_o | output | 1 | Presented request needs an external vector |
| vec_o | output | 8 | Fixed vector of the presented request |
| stat_o | output | 8 | Mask, enable and pending status |

## Verification
Two functions can collide on the edge line in a single cycle: the edge latch can be cleared (by a mask write with the clear bit, or by an acknowledge of that line) while a fresh rising edge arrives. The bench provokes both collisions: a clear write together with a new rising edge, and an enable strobe together with a disable or an acknowledge. It then reads `stat_o` one cycle later and expects the set-dominant and clear-dominant outcomes stated in R8 and R10. It also checks that an acknowledge of the non-maskable line leaves a latched edge intact.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NMASK = 3;

    localparam logic [7:0] VEC_NMI  = 8'h24;
    localparam logic [7:0] VEC_LOW  = 8'h2C;
    localparam logic [7:0] VEC_MID  = 8'h34;
    localparam logic [7:0] VEC_EDGE = 8'h3C;
    localparam logic [7:0] VEC_NONE = 8'h00;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_EXT,
        SRC_LOW,
        SRC_MID,
        SRC_EDGE,
        SRC_NMI
    } irq_src_e;

    typedef struct packed {
        logic nmi;
        logic edge_p;
        logic mid;
        logic low;
        logic ext;
    } irq_lines_t;

    typedef struct packed {
        logic             clr_edge;
        logic             load;
        logic [NMASK-1:0] mask;
    } mwr_word_t;

    typedef struct packed {
        logic             rsv;
        logic [NMASK-1:0] pend;
        logic             ie;
        logic [NMASK-1:0] mask;
    } stat_word_t;

    function automatic logic [7:0] vector_of(irq_src_e s);
        case (s)
            SRC_NMI:  return VEC_NMI;
            SRC_EDGE: return VEC_EDGE;
            SRC_MID:  return VEC_MID;
            SRC_LOW:  return VEC_LOW;
            default:  return VEC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = pin_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_i;
            pend_q <= rise | (pend_q & ~clr_i);
        end
    end

    assign pend_o = pend_q;

    p_rise_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (pin_i && !prev_q) |=> pend_o);

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(pin_i && !prev_q)) |=> !pend_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !clr_i) |=> pend_o);

endmodule

// File: rtl/irqv_mask_regs.sv
module irqv_mask_regs
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  mwr_word_t        wdata_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             ack_i,
    output logic [NMASK-1:0] mask_o,
    output logic             ie_o
);
    logic [NMASK-1:0] mask_q;
    logic             ie_q;
    logic             load;

    assign load = wr_i & wdata_i.load;

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[g] <= 1'b1;
            else if (load)
                mask_q[g] <= wdata_i.mask[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ie_q <= 1'b0;
        else if (di_i || ack_i)
            ie_q <= 1'b0;
        else if (ei_i)
            ie_q <= 1'b1;
    end

    assign mask_o = mask_q;
    assign ie_o   = ie_q;

    p_disable_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (di_i || ack_i) |=> !ie_o);

    p_enable_sets_r10: assert property (@(posedge clk) disable iff (rst)
        (ei_i && !di_i && !ack_i) |=> ie_o);

    p_mask_keep_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && wdata_i.load) |=> $stable(mask_o));

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  irq_lines_t       lines_i,
    input  logic [NMASK-1:0] mask_i,
    input  logic             ie_i,
    output irq_src_e         src_o
);
    logic [NMASK-1:0] live;

    assign live[0] = lines_i.low    & ~mask_i[0] & ie_i;
    assign live[1] = lines_i.mid    & ~mask_i[1] & ie_i;
    assign live[2] = lines_i.edge_p & ~mask_i[2] & ie_i;

    always_comb begin
        if (lines_i.nmi)
            src_o = SRC_NMI;
        else if (live[2])
            src_o = SRC_EDGE;
        else if (live[1])
            src_o = SRC_MID;
        else if (live[0])
            src_o = SRC_LOW;
        else if (lines_i.ext && ie_i)
            src_o = SRC_EXT;
        else
            src_o = SRC_NONE;
    end

endmodule

// File: rtl/irqv_front.sv
module irqv_front
    import irqv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       nmi_i,
    input  logic       irq_edge_i,
    input  logic       irq_mid_i,
    input  logic       irq_low_i,
    input  logic       irq_ext_i,
    input  logic       ei_i,
    input  logic       di_i,
    input  logic       ack_i,
    input  logic       mwr_i,
    input  logic [4:0] mwdata_i,
    output logic       req_o,
    output logic       ext_o,
    output logic [7:0] vec_o,
    output logic [7:0] stat_o
);
    mwr_word_t        wword;
    logic [NMASK-1:0] mask;
    logic             ie;
    logic             edge_pend;
    logic             edge_clr;
    irq_lines_t       lines;
    irq_src_e         src;
    stat_word_t       stat;

    assign wword = mwr_word_t'(mwdata_i);

    irqv_mask_regs u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (mwr_i),
        .wdata_i (wword),
        .ei_i    (ei_i),
        .di_i    (di_i),
        .ack_i   (ack_i),
        .mask_o  (mask),
        .ie_o    (ie)
    );

    assign edge_clr = (mwr_i & wword.clr_edge) | (ack_i & (src == SRC_EDGE));

    irqv_edge_latch u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (irq_edge_i),
        .clr_i  (edge_clr),
        .pend_o (edge_pend)
    );

    always_comb begin
        lines        = '0;
        lines.nmi    = nmi_i;
        lines.edge_p = edge_pend;
        lines.mid    = irq_mid_i;
        lines.low    = irq_low_i;
        lines.ext    = irq_ext_i;
    end

    irqv_arbiter u_arb (
        .lines_i (lines),
        .mask_i  (mask),
        .ie_i    (ie),
        .src_o   (src)
    );

    assign req_o = (src != SRC_NONE);
    assign ext_o = (src == SRC_EXT);
    assign vec_o = vector_of(src);

    always_comb begin
        stat      = '0;
        stat.mask = mask;
        stat.ie   = ie;
        stat.pend = {edge_pend, irq_mid_i, irq_low_i};
    end
    assign stat_o = stat;

    p_nmi_wins_r4: assert property (@(posedge clk) disable iff (rst)
        nmi_i |-> (req_o && vec_o == VEC_NMI && !ext_o));

    p_ext_vec_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ext_o |-> (req_o && vec_o == VEC_NONE));

    p_ack_drops_ie_r9: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !stat_o[3]);

    p_level_pend_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_o[4] == irq_low_i) && (stat_o[5] == irq_mid_i));

    p_no_req_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!nmi_i && !stat_o[3]) |-> !req_o);

endmodule

// File: tb/irqv_front_tb.sv
module irqv_front_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0] rq;
        logic       nmi, edg, mid, low, ext;
        logic       ei, di, ack, wr;
        logic [4:0] wd;
        logic       e_req, e_ext;
        logic [7:0] e_vec, e_stat;
    } row_t;

    localparam int NROWS = 25;
    localparam row_t TBL [NROWS] = '{
        '{4'd1,  1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h07}, // R1 idle
        '{4'd2,  1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 5'h08, 1'b0,1'b0,8'h00,8'h00}, // R2 unmask all
        '{4'd10, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h08}, // R10 enable
        '{4'd11, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b0,8'h2C,8'h18}, // R11 low
        '{4'd5,  1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b0,8'h34,8'h38}, // R5 mid over low
        '{4'd7,  1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b0,8'h3C,8'h78}, // R7 edge latched
        '{4'd2,  1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 5'h0C, 1'b1,1'b0,8'h34,8'h7C}, // R2 mask edge
        '{4'd2,  1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 5'h08, 1'b1,1'b0,8'h3C,8'h78}, // R2 unmask
        '{4'd9,  1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h30}, // R9 ack edge
        '{4'd4,  1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b0,8'h24,8'h30}, // R4 nmi, ie off
        '{4'd4,  1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, 5'h0F, 1'b1,1'b0,8'h24,8'h37}, // R4 nmi, masked
        '{4'd11, 1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b1, 5'h08, 1'b1,1'b0,8'h34,8'h38}, // R11 mid over ext
        '{4'd6,  1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b1,8'h00,8'h08}, // R6 ext
        '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h00}, // R9 ack ext
        '{4'd8,  1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 5'h10, 1'b0,1'b0,8'h00,8'h40}, // R8 set beats clear
        '{4'd8,  1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, 5'h10, 1'b0,1'b0,8'h00,8'h00}, // R8 clear
        '{4'd7,  1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h00}, // R7 level no relatch
        '{4'd10, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h08}, // R10 enable
        '{4'd10, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h40}, // R10 di beats ei
        '{4'd10, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b0,8'h3C,8'h48}, // R10 enable
        '{4'd10, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h00}, // R10 ack beats ei
        '{4'd7,  1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h40}, // R7 new edge
        '{4'd4,  1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 5'h00, 1'b1,1'b0,8'h24,8'h48}, // R4 nmi over edge
        '{4'd9,  1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0, 5'h00, 1'b1,1'b0,8'h24,8'h40}, // R9 nmi ack keeps latch
        '{4'd9,  1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 5'h00, 1'b0,1'b0,8'h00,8'h40}  // R9 latch intact
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nmi_i = 0, irq_edge_i = 0, irq_mid_i = 0, irq_low_i = 0, irq_ext_i = 0;
    logic       ei_i = 0, di_i = 0, ack_i = 0, mwr_i = 0;
    logic [4:0] mwdata_i = '0;
    logic       req_o, ext_o;
    logic [7:0] vec_o, stat_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqv_front u_dut (
        .clk(clk), .rst(rst), .nmi_i(nmi_i), .irq_edge_i(irq_edge_i),
        .irq_mid_i(irq_mid_i), .irq_low_i(irq_low_i), .irq_ext_i(irq_ext_i),
        .ei_i(ei_i), .di_i(di_i), .ack_i(ack_i), .mwr_i(mwr_i),
        .mwdata_i(mwdata_i), .req_o(req_o), .ext_o(ext_o),
        .vec_o(vec_o), .stat_o(stat_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input int rq, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic check_all(input int rq, input logic er, input logic ee,
                             input logic [7:0] ev, input logic [7:0] es);
        check({7'b0, req_o}, {7'b0, er}, rq, "req");
        check({7'b0, ext_o}, {7'b0, ee}, rq, "ext");
        check(vec_o, ev, rq, "vec");
        check(stat_o, es, rq, "stat");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check_all(1, 1'b0, 1'b0, 8'h00, 8'h07); // R1 right after reset

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            nmi_i = TBL[i].nmi; irq_edge_i = TBL[i].edg; irq_mid_i = TBL[i].mid;
            irq_low_i = TBL[i].low; irq_ext_i = TBL[i].ext;
            ei_i = TBL[i].ei; di_i = TBL[i].di; ack_i = TBL[i].ack;
            mwr_i = TBL[i].wr; mwdata_i = TBL[i].wd;
            @(posedge clk);
            #1 check_all(int'(TBL[i].rq), TBL[i].e_req, TBL[i].e_ext,
                         TBL[i].e_vec, TBL[i].e_stat);
        end

        // R1: reset in the middle of activity restores the reset state
        @(negedge clk);
        irq_edge_i = 0; nmi_i = 0; ei_i = 1; ack_i = 0; mwr_i = 1; mwdata_i = 5'h08;
        @(negedge clk);
        ei_i = 0; mwr_i = 0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check_all(1, 1'b0, 1'b0, 8'h00, 8'h07);

        // R3: low line masked but pending; bit 7 stays 0
        @(negedge clk);
        irq_low_i = 1; ei_i = 1;
        @(posedge clk);
        #1 check_all(3, 1'b0, 1'b0, 8'h00, 8'h1F);

        // R2: write without load bit leaves masks; ext held by ie
        @(negedge clk);
        ei_i = 0; mwr_i = 1; mwdata_i = 5'h00; irq_ext_i = 1;
        @(posedge clk);
        #1 check_all(2, 1'b1, 1'b1, 8'h00, 8'h1F);

        @(negedge clk);
        mwr_i = 0; irq_low_i = 0; irq_ext_i = 0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule